// File: doc/BRIEF.md
# DMX512 Slot Capture Receiver

This block sits behind a 250 kbaud, 9-bit UART receiver and rebuilds DMX512 packets from the bytes it hands over. Each received byte comes with its ninth bit, which is the stop bit, and with framing-error and overrun flags. A break is taken to be an all-zero byte whose ninth bit is low. The byte after a break is the start code, and only a zero start code lets the packet go on. After that the block counts slots. When the count reaches a start address set by three 4-bit switch reads, it captures a fixed run of consecutive channel values into a register file, which is read through a parallel port.

When a full run has been stored, the block gives a one-cycle completion pulse and sets a data-valid status. Receive errors set a sticky error flag and ask the UART to restart its receive logic. A mains half-cycle tick drives a no-traffic timer. When 256 half-cycles pass with no byte, the timer clears data-valid and sends the parser back to waiting for a break.

Top module: `dmx_slot_rx`

## Requirements
- R1: After a synchronous active-low reset, every capture register, `data_valid`, `err_flag`, `packet_done` and `rx_restart` read zero.
- R2: A byte with `rx_ninth`=0 and `rx_data`=0x00 is a break and arms start-code detection. A ninth-low byte that is nonzero is not a break: a zero start code that follows it starts nothing.
- R3: Any byte with `rx_ninth`=0 sends the parser back to waiting for a break, even in the middle of a capture. Channels already written keep their values and no completion is signalled.
- R4: A nonzero start code (the first ninth-high byte after a break) aborts the packet. Later slots change no channel until a new break arrives.
- R5: The start address is `{addr_sw_top[0], addr_sw_hi, addr_sw_lo}`. The other bits of `addr_sw_top` are ignored. Slot 1 is the first byte after the start code. The byte whose slot number equals the address is stored as channel 0. An address of 0 never matches.
- R6: Channel k (for k from 0 to NCH-1, with NCH=6) receives slot address+k. Each register is written in the cycle after its byte arrives. When channel NCH-1 is written, `packet_done` pulses high for exactly one cycle and `data_valid` goes high.
- R7: Bytes that follow a completed capture change no channel until the next break.
- R8: A byte flagged with a framing error or an overrun sets `err_flag`, which stays set until reset. It also gives a one-cycle `rx_restart` pulse in the next cycle. The byte is still parsed and stored as usual.
- R9: Every received byte clears the no-traffic count. Each `half_cycle_tick` with no byte adds one to it. On the 256th consecutive tick, `data_valid` drops and the parser is forced to wait for a break.
- R10: Channel k is presented on `chan_data[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| rx_ninth | input | 1 | Ninth (stop) bit of the byte |
| rx_frame_err | input | 1 | Framing error on this byte |
| rx_overrun | input | 1 | Receiver overrun seen with this byte |
| half_cycle_tick | input | 1 | One-cycle pulse once per mains half-cycle |
| addr_sw_lo | input | 4 | Switch read giving address bits 3:0 |
| addr_sw_hi | input | 4 | Switch read giving address bits 7:4 |
| addr_sw_top | input | 4 | Switch read; bit 0 is address bit 8 |
| chan_data | output | 48 | Captured channels, channel k at bits 8k+7:8k |
| packet_done | output | 1 | One-cycle pulse when a capture run completes |
| data_valid | output | 1 | Set by completion, cleared by timeout |
| err_flag | output | 1 | Sticky receive-error flag |
| rx_restart | output | 1 | One-cycle request to reset the UART receive logic |

## Verification
The capture path is run with packets that use several start addresses: one right after the start code, one whose low nibble is all ones, and one that needs address bit 8 with junk in the upper switch bits. Each slot carries its own value, so storing the wrong slot, shifting the channel order, or decoding the address wrongly shows up as a mismatch. Other packets use a nonzero start code, an address beyond the last slot, and address zero; each of these must leave the channels as they were and give no completion. Directed runs cover a ninth-low byte in the middle of a capture, a non-break byte before the start code, error-flagged bytes, bytes after completion, and the timeout at tick 255 against tick 256, including a timeout while the parser waits for the start code.

// File: rtl/dmx_rx_pkg.sv
// Shared types for the DMX512 slot capture receiver.
package dmx_rx_pkg;
    // Parser phases, from break hunt through channel capture.
    typedef enum logic [1:0] {
        PH_WAIT_BREAK = 2'd0,
        PH_WAIT_START = 2'd1,
        PH_HUNT_ADDR  = 2'd2,
        PH_CAPTURE    = 2'd3
    } dmx_phase_e;
endpackage

// File: rtl/dmx_frame_fsm.sv
// Framing state machine: finds a break, checks the start code, counts slots
// and produces channel write strobes.
// Assumes byte_vld is a one-cycle strobe and force_idle only comes with no byte.
module dmx_frame_fsm
    import dmx_rx_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int DW     = 8,
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 16,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DW-1:0]     byte_val,
    input  logic              stop_bit,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              force_idle,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              fin
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    dmx_phase_e        phase_q, phase_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [IDX_W-1:0]  idx_q, idx_d;

    // Next-state, slot counter and write strobe decode for one received byte.
    always_comb begin
        phase_d = phase_q;
        slot_d  = slot_q;
        idx_d   = idx_q;
        wr_en   = 1'b0;
        wr_idx  = '0;
        fin     = 1'b0;
        if (force_idle) begin
            phase_d = PH_WAIT_BREAK;
        end else if (byte_vld) begin
            if (!stop_bit) begin
                phase_d = (byte_val == '0) ? PH_WAIT_START : PH_WAIT_BREAK;
            end else begin
                case (phase_q)
                    PH_WAIT_BREAK: phase_d = PH_WAIT_BREAK;
                    PH_WAIT_START: begin
                        slot_d  = '0;
                        idx_d   = '0;
                        phase_d = (byte_val == '0) ? PH_HUNT_ADDR : PH_WAIT_BREAK;
                    end
                    PH_HUNT_ADDR: begin
                        slot_d = slot_q + 1'b1;
                        if (slot_d == SLOT_W'(start_addr)) begin
                            wr_en = 1'b1;
                            if (NCH == 1) begin
                                fin     = 1'b1;
                                phase_d = PH_WAIT_BREAK;
                            end else begin
                                idx_d   = IDX_W'(1);
                                phase_d = PH_CAPTURE;
                            end
                        end
                    end
                    PH_CAPTURE: begin
                        wr_en  = 1'b1;
                        wr_idx = idx_q;
                        if (idx_q == LAST_IDX) begin
                            fin     = 1'b1;
                            phase_d = PH_WAIT_BREAK;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    default: phase_d = PH_WAIT_BREAK;
                endcase
            end
        end
    end

    // Parser state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT_BREAK;
            slot_q  <= '0;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/dmx_chan_regs.sv
// Capture register file: one byte register per channel, written by index.
// Assumes wr_idx is below NCH whenever wr_en is high.
module dmx_chan_regs #(
    parameter int NCH    = 6,
    parameter int DW     = 8,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_val,
    output logic [NCH*DW-1:0] rd_bus
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] val_q;
        // Store the byte when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                val_q <= wr_val;
        end
        assign rd_bus[g*DW +: DW] = val_q;
    end
endmodule

// File: rtl/dmx_idle_timer.sv
// No-traffic timer counting mains half-cycles since the last received byte.
// A received byte takes priority over a tick in the same cycle.
module dmx_idle_timer #(
    parameter int TMO_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic tick,
    output logic expire
);
    logic [TMO_W-1:0] cnt_q;

    assign expire = tick && !byte_vld && (cnt_q == '1);

    // Clear on traffic, count ticks otherwise (wraps at the top).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (byte_vld)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dmx_slot_rx.sv
// DMX512 slot capture receiver top: ties parser, register file and timer
// together and holds the status flags. Assumes a byte-level UART in front.
module dmx_slot_rx #(
    parameter int NCH    = 6,
    parameter int DW     = 8,
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 16,
    parameter int TMO_W  = 8,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_ninth,
    input  logic              rx_frame_err,
    input  logic              rx_overrun,
    input  logic              half_cycle_tick,
    input  logic [3:0]        addr_sw_lo,
    input  logic [3:0]        addr_sw_hi,
    input  logic [3:0]        addr_sw_top,
    output logic [NCH*DW-1:0] chan_data,
    output logic              packet_done,
    output logic              data_valid,
    output logic              err_flag,
    output logic              rx_restart
);
    logic [ADDR_W-1:0] start_addr;
    logic              wr_en, fin, expire, bad_byte;
    logic [IDX_W-1:0]  wr_idx;

    assign start_addr = ADDR_W'({addr_sw_top[0], addr_sw_hi, addr_sw_lo});
    assign bad_byte   = rx_valid && (rx_frame_err || rx_overrun);

    dmx_frame_fsm #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_vld(rx_valid), .byte_val(rx_data),
        .stop_bit(rx_ninth), .start_addr(start_addr), .force_idle(expire),
        .wr_en(wr_en), .wr_idx(wr_idx), .fin(fin)
    );

    dmx_chan_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_val(rx_data), .rd_bus(chan_data)
    );

    dmx_idle_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .byte_vld(rx_valid),
        .tick(half_cycle_tick), .expire(expire)
    );

    // Status flags: completion pulse, data-valid, sticky error, restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            packet_done <= 1'b0;
            data_valid  <= 1'b0;
            err_flag    <= 1'b0;
            rx_restart  <= 1'b0;
        end else begin
            packet_done <= fin;
            rx_restart  <= bad_byte;
            if (bad_byte)
                err_flag <= 1'b1;
            if (fin)
                data_valid <= 1'b1;
            else if (expire)
                data_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dmx_slot_rx_chk.sv
// Temporal checks on the receiver ports, attached by bind.
module dmx_slot_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic half_cycle_tick,
    input logic packet_done,
    input logic data_valid,
    input logic err_flag,
    input logic rx_restart
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        packet_done |=> !packet_done);
    // R6
    done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        packet_done |-> data_valid);
    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> packet_done);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    // R8
    restart_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_restart |-> err_flag);
    // R8
    restart_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_restart |-> $past(rx_valid));
    // R9
    valid_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid) |-> ($past(half_cycle_tick) && !$past(rx_valid)));
endmodule

bind dmx_slot_rx dmx_slot_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
    .half_cycle_tick(half_cycle_tick), .packet_done(packet_done),
    .data_valid(data_valid), .err_flag(err_flag), .rx_restart(rx_restart)
);

// File: tb/dmx_slot_rx_tb.sv
module dmx_slot_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int NVEC = 7;
    // Table: start address, start code, slots sent, value seed.
    localparam int T_ADDR [NVEC] = '{1, 10, 261, 5, 300, 0, 15};
    localparam int T_SC   [NVEC] = '{0, 0, 0, 8'h17, 0, 0, 0};
    localparam int T_NSL  [NVEC] = '{8, 20, 270, 12, 30, 10, 25};
    localparam int T_SEED [NVEC] = '{3, 40, 91, 5, 9, 7, 200};

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_ninth = 1, rx_frame_err = 0, rx_overrun = 0, half_cycle_tick = 0;
    logic [7:0] rx_data = 0;
    logic [3:0] addr_sw_lo = 0, addr_sw_hi = 0, addr_sw_top = 0;
    logic [NCH*8-1:0] chan_data;
    logic packet_done, data_valid, err_flag, rx_restart;

    int checks = 0, failures = 0, done_cnt = 0, rst_cnt = 0, cyc = 0;
    logic [7:0] exp_ch [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx_slot_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ninth(rx_ninth), .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun),
        .half_cycle_tick(half_cycle_tick), .addr_sw_lo(addr_sw_lo),
        .addr_sw_hi(addr_sw_hi), .addr_sw_top(addr_sw_top), .chan_data(chan_data),
        .packet_done(packet_done), .data_valid(data_valid), .err_flag(err_flag),
        .rx_restart(rx_restart)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (packet_done) done_cnt <= done_cnt + 1;
        if (rx_restart) rst_cnt <= rst_cnt + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic logic [7:0] slot_val(int s, int seed);
        return 8'((s * 7 + seed) & 255);
    endfunction

    function automatic logic [NCH*8-1:0] exp_bus();
        logic [NCH*8-1:0] b;
        for (int k = 0; k < NCH; k++) b[k*8 +: 8] = exp_ch[k];   // R10 layout
        return b;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] d, logic ninth, logic fe = 0, logic ov = 0);
        rx_data = d; rx_ninth = ninth; rx_frame_err = fe; rx_overrun = ov; rx_valid = 1;
        @(negedge clk);
        rx_valid = 0; rx_frame_err = 0; rx_overrun = 0; rx_ninth = 1;
    endtask

    task automatic tick();
        half_cycle_tick = 1;
        @(negedge clk);
        half_cycle_tick = 0;
    endtask

    task automatic set_addr(int a);
        addr_sw_lo = 4'(a); addr_sw_hi = 4'(a >> 4);
        addr_sw_top = {3'b101, 1'(a >> 8)};       // upper bits are junk (R5)
    endtask

    task automatic slots(int first, int last, int seed);
        for (int s = first; s <= last; s++) send(slot_val(s, seed), 1);
    endtask

    initial begin
        int d0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {chan_data, packet_done, data_valid, err_flag, rx_restart}, '0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            d0 = done_cnt;
            set_addr(T_ADDR[v]);
            send(8'h00, 0);                          // break
            send(8'(T_SC[v]), 1);                    // start code
            slots(1, T_NSL[v], T_SEED[v]);
            repeat (2) @(negedge clk);
            if (T_SC[v] == 0 && T_ADDR[v] != 0 && T_ADDR[v] + NCH - 1 <= T_NSL[v]) begin
                for (int k = 0; k < NCH; k++) exp_ch[k] = slot_val(T_ADDR[v] + k, T_SEED[v]);
                check("R6 done count", 64'(done_cnt - d0), 64'd1);
            end else begin
                check("R4/R5 no completion", 64'(done_cnt - d0), 64'd0);
            end
            check("R5/R7/R10 channels", 64'(chan_data), 64'(exp_bus()));
        end
        check("R6 data_valid", 64'(data_valid), 64'd1);

        // R3 ninth-low byte mid-capture aborts; R2 nonzero ninth-low is no break
        d0 = done_cnt;
        set_addr(2);
        send(8'h00, 0); send(8'h00, 1);
        slots(1, 3, 60);
        exp_ch[0] = slot_val(2, 60); exp_ch[1] = slot_val(3, 60);
        send(8'h44, 0);
        slots(4, 10, 60);
        send(8'h00, 1);                              // zero start code after non-break
        slots(1, 10, 77);
        repeat (2) @(negedge clk);
        check("R3 partial channels", 64'(chan_data), 64'(exp_bus()));
        check("R2/R3 no completion", 64'(done_cnt - d0), 64'd0);

        // R8 framing error and overrun bytes still captured
        d0 = done_cnt; r0 = rst_cnt;
        set_addr(3);
        send(8'h00, 0); send(8'h00, 1);
        slots(1, 3, 11);
        send(slot_val(4, 11), 1, 1, 0);
        @(negedge clk);
        check("R8 restart pulse", 64'(rx_restart), 64'd0);
        check("R8 err_flag", 64'(err_flag), 64'd1);
        send(slot_val(5, 11), 1, 0, 1);
        slots(6, 9, 11);
        repeat (2) @(negedge clk);
        for (int k = 0; k < NCH; k++) exp_ch[k] = slot_val(3 + k, 11);
        check("R8 stored after error", 64'(chan_data), 64'(exp_bus()));
        check("R8 restart count", 64'(rst_cnt - r0), 64'd2);
        check("R8 completion", 64'(done_cnt - d0), 64'd1);

        // R9 timeout: a byte clears the count, 256th tick drops data_valid
        for (int i = 0; i < 200; i++) tick();
        send(8'h33, 1);
        for (int i = 0; i < 255; i++) tick();
        check("R9 valid at 255", 64'(data_valid), 64'd1);
        tick();
        check("R9 valid at 256", 64'(data_valid), 64'd0);

        // R9 timeout while waiting for start code forces break hunt
        d0 = done_cnt;
        set_addr(1);
        send(8'h00, 0);
        for (int i = 0; i < 256; i++) tick();
        send(8'h00, 1);
        slots(1, 8, 123);
        repeat (2) @(negedge clk);
        check("R9 forced idle channels", 64'(chan_data), 64'(exp_bus()));
        check("R9 forced idle done", 64'(done_cnt - d0), 64'd0);
        check("R8 err stays", 64'(err_flag), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule